// File: doc/BRIEF.md
# Move-Only Transport-Triggered Processor Core

This core runs programs made of one kind of step: copy one word from a source address to a destination address. There is no opcode and nothing to decode. Each program word holds only the two addresses. Arithmetic is done by processing elements that sit inside the data address space. Each one has two operand cells and a result cell. A move into the second operand cell starts the operation. The result later shows up in the element's result cell, and a later move copies it out. A new function is added by mapping another element into the address space; the instruction format stays the same.

A host loads the program memory and the data RAM through a load port while the core is idle, then pulses `start`. The core then performs one move per cycle from program word 0. It stalls when a result is not ready yet or when an element is still busy. It stops when a move targets the halt address. Values written to the output address appear on `out_data` for one cycle, flagged by `out_vld`.

Top module: `mover_core`

## Requirements
- R1: A program word carries the source address in bits [15:8] and the destination address in bits [7:0]. It has no other field. An executed move writes the value read from the source address into the destination address.
- R2: Addresses 0x00 to 0xDF are RAM. Element k sits at 0xE0+4k:
  - +0 is operand A.
  - +1 is operand B, which also triggers the operation.
  - +2 is the result cell.
  - Element 0 adds and element 1 multiplies, each keeping the low 16 bits.
  - Reading any other address at or above 0xE0 returns 0.
- R3: Without stalls the core retires one move per cycle, so an N-move program that ends in a halt keeps `busy` high for exactly N cycles.
- R4: A move into operand B starts the operation on the latched operand A and the moved value. The result becomes valid 1 cycle (adder) or 4 cycles (multiplier) after that move retires.
- R5: A move whose source is a result cell with no valid result holds the program counter until the result is valid. Reading a result right after its trigger therefore costs the element's latency in extra cycles.
- R6: Reading a result cell clears its valid flag. A second read with no new trigger stalls indefinitely.
- R7: A move into operand B of a busy element stalls until the element is idle. A new trigger discards any unread earlier result.
- R8: A move to 0xFE loads the program counter from the low 8 bits of the moved value. This is an unconditional jump.
- R9: A move to 0xFF halts the core: `busy` is low from the cycle after that move.
- R10: A move to 0xF0 puts the moved value on `out_data`, with `out_vld` high for exactly the following cycle per such move.
- R11: After reset `busy` and `out_vld` are low. A `start` pulse while idle begins at program word 0. Load-port writes (`ld_sel` 0 = program word, 1 = data RAM) take effect only while idle. The RAM keeps its contents across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at program word 0 when idle |
| ld_en | input | 1 | Load-port write strobe (idle only) |
| ld_sel | input | 1 | Load target: 0 program memory, 1 data RAM |
| ld_addr | input | 8 | Load address |
| ld_data | input | 16 | Load value |
| busy | output | 1 | Core is executing a program |
| out_vld | output | 1 | `out_data` holds a value moved to 0xF0 |
| out_data | output | 16 | Last value moved to the output address |

## Verification
Every result reaches the ports with fixed timing:
- An output move shows on `out_vld` in the cycle after it retires.
- A halt drops `busy` one cycle after it retires.
- An element result is valid one latency after its trigger retires.

The bench therefore predicts the exact count of `busy` cycles for each program: the number of moves, plus the full latency for every read or trigger that waits on an element. It compares that count at the falling edge. Output values are captured at falling edges as well, in order, and compared against arithmetic done in the bench. The hang case is checked by seeing `busy` still high, with only one output, after a fixed wait.

// File: rtl/mover_pkg.sv
package mover_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] PE_BASE   = 8'hE0;
    localparam logic [ADDR_W-1:0] OUT_ADDR  = 8'hF0;
    localparam logic [ADDR_W-1:0] JUMP_ADDR = 8'hFE;
    localparam logic [ADDR_W-1:0] HALT_ADDR = 8'hFF;

    typedef enum logic [1:0] {
        CELL_OPA = 2'd0,
        CELL_OPB = 2'd1,
        CELL_RES = 2'd2,
        CELL_NONE = 2'd3
    } pe_cell_e;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_MUL = 1'b1
    } pe_op_e;

endpackage

// File: rtl/mover_ram.sv
module mover_ram #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 224,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we && int'(waddr) < DEPTH) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(raddr) < DEPTH) begin
            rdata = mem_q[raddr];
        end
    end
endmodule

// File: rtl/mover_pe.sv
module mover_pe
    import mover_pkg::*;
#(
    parameter int     DATA_W = 16,
    parameter int     LAT    = 1,
    parameter pe_op_e OP     = OP_ADD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic              take,
    input  logic [DATA_W-1:0] wdata,
    output logic              ready,
    output logic              res_vld,
    output logic [DATA_W-1:0] res
);
    localparam int CNT_W = $clog2(LAT + 1);

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] opa;
        logic [DATA_W-1:0] opb;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] res;
        logic              vld;
    } pe_st_t;

    pe_st_t st_d, st_q;
    logic [DATA_W-1:0] calc;

    generate
        if (OP == OP_MUL) begin : g_mul
            assign calc = st_q.opa * st_q.opb;
        end else begin : g_add
            assign calc = st_q.opa + st_q.opb;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (wr_a) begin
            st_d.a = wdata;
        end
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.res = calc;
                st_d.vld = 1'b1;
            end
        end
        if (take) begin
            st_d.vld = 1'b0;
        end
        if (wr_b) begin
            st_d.opa = st_q.a;
            st_d.opb = wdata;
            st_d.cnt = CNT_W'(LAT);
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready   = (st_q.cnt == '0);
    assign res_vld = st_q.vld;
    assign res     = st_q.res;
endmodule

// File: rtl/mover_core.sv
module mover_core
    import mover_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int PC_W      = 8,
    parameter int RAM_DEPTH = 224,
    parameter int NUM_PE    = 2,
    parameter int ADD_LAT   = 1,
    parameter int MUL_LAT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ld_en,
    input  logic              ld_sel,
    input  logic [7:0]        ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output logic              busy,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data
);
    localparam int INSN_W   = 2 * ADDR_W;
    localparam int PM_DEPTH = 1 << PC_W;
    localparam int PE_SPAN  = 4 * NUM_PE;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic              running;
        logic [DATA_W-1:0] out_data;
        logic              out_vld;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [INSN_W-1:0] insn;
    logic [ADDR_W-1:0] src, dst;
    logic              src_ram, dst_ram, src_pe, dst_pe, src_is_res, dst_is_trig;
    logic [1:0]        src_idx, dst_idx;
    pe_cell_e          src_cell, dst_cell;
    logic [DATA_W-1:0] src_data, ram_rd;
    logic              stall, fire, halt_hit, jump_hit, res_wait, trig_wait;

    logic [NUM_PE-1:0] pe_wr_a, pe_wr_b, pe_take, pe_ready, pe_vld;
    logic [DATA_W-1:0] pe_res [NUM_PE];

    logic              pm_we, ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [DATA_W-1:0] ram_wdata;

    assign pm_we = ld_en && !ld_sel && !st_q.running && (int'(ld_addr) < PM_DEPTH);

    mover_ram #(.WIDTH(INSN_W), .DEPTH(PM_DEPTH), .AW(PC_W)) u_pmem (
        .clk   (clk),
        .we    (pm_we),
        .waddr (ld_addr[PC_W-1:0]),
        .wdata (ld_data[INSN_W-1:0]),
        .raddr (st_q.pc),
        .rdata (insn)
    );

    assign src = insn[INSN_W-1:ADDR_W];
    assign dst = insn[ADDR_W-1:0];

    always_comb begin
        src_ram     = int'(src) < RAM_DEPTH;
        dst_ram     = int'(dst) < RAM_DEPTH;
        src_pe      = (src >= PE_BASE) && (int'(src) < int'(PE_BASE) + PE_SPAN);
        dst_pe      = (dst >= PE_BASE) && (int'(dst) < int'(PE_BASE) + PE_SPAN);
        src_idx     = src[3:2];
        dst_idx     = dst[3:2];
        src_cell    = pe_cell_e'(src[1:0]);
        dst_cell    = pe_cell_e'(dst[1:0]);
        src_is_res  = src_pe && (src_cell == CELL_RES);
        dst_is_trig = dst_pe && (dst_cell == CELL_OPB);
        halt_hit    = (dst == HALT_ADDR);
        jump_hit    = (dst == JUMP_ADDR);
    end

    always_comb begin
        src_data  = src_ram ? ram_rd : '0;
        res_wait  = 1'b0;
        trig_wait = 1'b0;
        for (int k = 0; k < NUM_PE; k++) begin
            if (src_is_res && int'(src_idx) == k) begin
                src_data = pe_res[k];
                res_wait = !pe_vld[k];
            end
            if (dst_is_trig && int'(dst_idx) == k) begin
                trig_wait = !pe_ready[k];
            end
        end
    end

    assign stall = st_q.running && (res_wait || trig_wait);
    assign fire  = st_q.running && !stall;

    always_comb begin
        for (int k = 0; k < NUM_PE; k++) begin
            pe_wr_a[k] = fire && dst_pe && int'(dst_idx) == k && dst_cell == CELL_OPA;
            pe_wr_b[k] = fire && dst_is_trig && int'(dst_idx) == k;
            pe_take[k] = fire && src_is_res && int'(src_idx) == k;
        end
    end

    generate
        for (genvar k = 0; k < NUM_PE; k++) begin : g_pe
            localparam pe_op_e KOP  = (k % 2 == 0) ? OP_ADD : OP_MUL;
            localparam int     KLAT = (k % 2 == 0) ? ADD_LAT : MUL_LAT;
            mover_pe #(.DATA_W(DATA_W), .LAT(KLAT), .OP(KOP)) u_pe (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_a    (pe_wr_a[k]),
                .wr_b    (pe_wr_b[k]),
                .take    (pe_take[k]),
                .wdata   (src_data),
                .ready   (pe_ready[k]),
                .res_vld (pe_vld[k]),
                .res     (pe_res[k])
            );
        end
    endgenerate

    always_comb begin
        ram_we    = 1'b0;
        ram_waddr = dst;
        ram_wdata = src_data;
        if (fire && dst_ram) begin
            ram_we = 1'b1;
        end else if (ld_en && ld_sel && !st_q.running && int'(ld_addr) < RAM_DEPTH) begin
            ram_we    = 1'b1;
            ram_waddr = ld_addr;
            ram_wdata = ld_data;
        end
    end

    mover_ram #(.WIDTH(DATA_W), .DEPTH(RAM_DEPTH), .AW(ADDR_W)) u_dmem (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (src),
        .rdata (ram_rd)
    );

    always_comb begin
        st_d         = st_q;
        st_d.out_vld = 1'b0;
        if (!st_q.running) begin
            if (start) begin
                st_d.pc      = '0;
                st_d.running = 1'b1;
            end
        end else if (fire) begin
            st_d.pc = st_q.pc + 1'b1;
            if (dst == OUT_ADDR) begin
                st_d.out_data = src_data;
                st_d.out_vld  = 1'b1;
            end
            if (jump_hit) begin
                st_d.pc = src_data[PC_W-1:0];
            end
            if (halt_hit) begin
                st_d.running = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.running;
    assign out_vld  = st_q.out_vld;
    assign out_data = st_q.out_data;

    logic [PC_W-1:0] pc_now;
    logic            trig_blocked, take_early;
    assign pc_now       = st_q.pc;
    assign trig_blocked = |(pe_wr_b & ~pe_ready);
    assign take_early   = |(pe_take & ~pe_vld);
endmodule

// File: rtl/mover_checks.sv
module mover_checks #(
    parameter int PC_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            stall,
    input logic            fire,
    input logic            halt_hit,
    input logic            jump_hit,
    input logic            out_vld,
    input logic [PC_W-1:0] pc,
    input logic            trig_blocked,
    input logic            take_early
);
    a_r5_stall_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stall) |=> ($stable(pc) && busy));

    a_r3_pc_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fire && !jump_hit && !halt_hit) |=> (pc == PC_W'($past(pc) + 1)));

    a_r9_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fire && halt_hit) |=> !busy);

    a_r10_out_from_move: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(busy));

    a_r7_no_trigger_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_blocked);

    a_r6_read_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !take_early);
endmodule

bind mover_core mover_checks #(.PC_W(PC_W)) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .stall        (stall),
    .fire         (fire),
    .halt_hit     (halt_hit),
    .jump_hit     (jump_hit),
    .out_vld      (out_vld),
    .pc           (pc_now),
    .trig_blocked (trig_blocked),
    .take_early   (take_early)
);

// File: tb/mover_core_bench.sv
`timescale 1ns/1ps
module mover_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ld_en = 1'b0;
    logic        ld_sel = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic        busy, out_vld;
    logic [15:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    int out_total = 0;
    logic [15:0] outs [64];

    always #2.5 clk = ~clk;

    mover_core u_mover_core (
        .clk(clk), .rst_n(rst_n), .start(start), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_addr(ld_addr), .ld_data(ld_data), .busy(busy), .out_vld(out_vld),
        .out_data(out_data)
    );

    always @(negedge clk) begin
        if (out_vld && out_total < 64) begin
            outs[out_total] = out_data;
            out_total = out_total + 1;
        end
    end

    function automatic logic [15:0] mv(input logic [7:0] s, input logic [7:0] d);
        return {s, d};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic load(input logic sel, input logic [7:0] a, input logic [15:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_addr = a; ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Pulse start, count busy cycles up to limit; base gives first output index.
    task automatic run(input int limit, output int cyc, output int base);
        base = out_total;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (busy && cyc < limit) begin
            cyc++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R11 busy after reset", busy, 0);
        check("R11 out_vld after reset", out_vld, 0);
    endtask

    task automatic t_copy();
        int cyc, b;
        load(1, 8'h10, 16'h1234);
        load(0, 8'd0, mv(8'h10, 8'hDF));
        load(0, 8'd1, mv(8'hDF, 8'hF0));
        load(0, 8'd2, mv(8'h00, 8'hFF));
        run(100, cyc, b);
        check("R3 copy cycles", cyc, 3);
        check("R1 copy via RAM top", outs[b], 16'h1234);
        check("R10 one pulse per out move", out_total - b, 1);
        check("R9 idle after halt", busy, 0);
    endtask

    task automatic t_add();
        int cyc, b;
        load(1, 8'h10, 16'hFFF0);
        load(1, 8'h11, 16'h0025);
        load(0, 8'd0, mv(8'h10, 8'hE0));
        load(0, 8'd1, mv(8'h11, 8'hE1));
        load(0, 8'd2, mv(8'hE2, 8'hF0));
        load(0, 8'd3, mv(8'h00, 8'hFF));
        run(100, cyc, b);
        check("R4 add wraps", outs[b], 16'h0015);
        check("R5 add stall cycles", cyc, 4 + 1);
    endtask

    task automatic t_mul();
        int cyc, b;
        load(1, 8'h10, 16'd300);
        load(1, 8'h11, 16'd500);
        load(0, 8'd0, mv(8'h10, 8'hE4));
        load(0, 8'd1, mv(8'h11, 8'hE5));
        load(0, 8'd2, mv(8'hE6, 8'hF0));
        load(0, 8'd3, mv(8'h00, 8'hFF));
        run(100, cyc, b);
        check("R4 mul low bits", outs[b], (300 * 500) % 65536);
        check("R5 mul stall cycles", cyc, 4 + 4);
    endtask

    task automatic t_retrigger();
        int cyc, b;
        load(1, 8'h10, 16'd3);
        load(1, 8'h11, 16'd5);
        load(1, 8'h12, 16'd7);
        load(0, 8'd0, mv(8'h10, 8'hE4));
        load(0, 8'd1, mv(8'h11, 8'hE5));
        load(0, 8'd2, mv(8'h12, 8'hE5));
        load(0, 8'd3, mv(8'hE6, 8'hF0));
        load(0, 8'd4, mv(8'h00, 8'hFF));
        run(100, cyc, b);
        check("R7 busy trigger stall cycles", cyc, 5 + 4 + 4);
        check("R7 second product wins", outs[b], 21);
        check("R7 single output", out_total - b, 1);
    endtask

    task automatic t_jump();
        int cyc, b;
        load(1, 8'h10, 16'hAAAA);
        load(1, 8'h11, 16'hBBBB);
        load(1, 8'h12, 16'hCCCC);
        load(1, 8'h13, 16'h0004);
        load(0, 8'd0, mv(8'h10, 8'hF0));
        load(0, 8'd1, mv(8'h13, 8'hFE));
        load(0, 8'd2, mv(8'h11, 8'hF0));
        load(0, 8'd3, mv(8'h11, 8'hF0));
        load(0, 8'd4, mv(8'h12, 8'hF0));
        load(0, 8'd5, mv(8'h00, 8'hFF));
        run(100, cyc, b);
        check("R8 jump cycles", cyc, 4);
        check("R8 outputs count", out_total - b, 2);
        check("R8 first out", outs[b], 16'hAAAA);
        check("R8 out after jump", outs[b + 1], 16'hCCCC);
    endtask

    task automatic t_unmapped();
        int cyc, b;
        load(0, 8'd0, mv(8'hF5, 8'hF0));
        load(0, 8'd1, mv(8'hE3, 8'hF0));
        load(0, 8'd2, mv(8'h00, 8'hFF));
        run(100, cyc, b);
        check("R2 unmapped count", out_total - b, 2);
        check("R2 unmapped 0xF5 reads zero", outs[b], 0);
        check("R2 reserved cell reads zero", outs[b + 1], 0);
    endtask

    task automatic t_hang();
        int cyc, b;
        load(1, 8'h10, 16'd40);
        load(1, 8'h11, 16'd2);
        load(0, 8'd0, mv(8'h10, 8'hE0));
        load(0, 8'd1, mv(8'h11, 8'hE1));
        load(0, 8'd2, mv(8'hE2, 8'hF0));
        load(0, 8'd3, mv(8'hE2, 8'hF0));
        load(0, 8'd4, mv(8'h00, 8'hFF));
        run(40, cyc, b);
        check("R6 second read hangs", busy, 1);
        check("R6 one output before hang", out_total - b, 1);
        check("R6 first read value", outs[b], 42);
        load(1, 8'h10, 16'd999);
        do_reset();
        load(0, 8'd0, mv(8'h10, 8'hF0));
        load(0, 8'd1, mv(8'h00, 8'hFF));
        run(100, cyc, b);
        check("R11 load ignored while running", outs[b], 40);
    endtask

    initial begin
        #(150000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_copy();
        t_add();
        t_mul();
        t_retrigger();
        t_jump();
        t_unmapped();
        t_hang();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule